// File: doc/BRIEF.md
# Debug Hardware Breakpoint Unit

This block sits beside a small 8-bit CPU and its background debug controller. It holds one match address and compares it, over every bit, with the address of each CPU fetch. When a fetch hits, the block can react in one of two ways. In force mode it arms a pending request and raises a background request at the next instruction boundary. The hit address does not need to hold an opcode. In tag mode it marks the fetched byte inside a small modelled instruction queue. It raises the request only when that marked byte is popped from the head of the queue for execution. A queue flush, such as a taken branch, drops any marks still in flight.

The match address and a small control/status word are reached only through a debug-side register port, which is separate from the user memory map. The control word holds the enable, the mode select and the debug clock source select. It also reports whether the CPU is in a low-power wait or stop state, and whether a debug memory access collided with entry to such a state. The background request is a single-cycle pulse. Hits are ignored while the CPU is already in background mode.

Top module: `dbg_brk_unit`

## Requirements
- R1: After synchronous reset, the match address reads 0, the control word reads 0, `dbg_clk_sel` is 0 and `brk_req` is 0.
- R2: Register select 0 reads and writes the 16-bit match address. Select 1 is the control word: bit 0 enable, bit 1 mode (1 = force, 0 = tag), bit 2 clock select, bit 3 wait/stop status (read-only), bit 4 collision flag. All other control bits read 0.
- R3: While enable is 0, no fetch and no queue pop ever produces `brk_req`.
- R4: In force mode, a hit arms a request. `brk_req` pulses in the cycle after the first `insn_bound` seen in the cycle of the hit or later.
- R5: In tag mode, a hit tags the fetched byte as it enters the queue. `brk_req` pulses in the cycle after that byte is popped from the queue head, and popping untagged bytes does nothing.
- R6: A queue flush discards every tag in the queue, so later pops produce no request.
- R7: `brk_req` is at most one cycle wide, and no request is made while `bdm_active` is 1.
- R8: The comparison covers all 16 address bits, so an address that differs from the match value in any one bit, including bit 15, is not a hit.
- R9: The wait/stop status bit reads 1 in the cycle after `cpu_wait_stop` is 1. It stays 1 while `bdm_active` is held and clears once both are low.
- R10: A `mem_fail_ws` pulse sets the collision flag. Writing 1 to bit 4 of the control word clears it, and a set in the same cycle wins over the clear.
- R11: `dbg_clk_sel` follows the control word's clock select bit: 0 selects the alternate source and 1 selects the bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sel | input | 2 | Debug register select |
| dbg_we | input | 1 | Debug register write strobe |
| dbg_wdata | input | 16 | Debug register write data |
| dbg_rdata | output | 16 | Debug register read data (combinational) |
| fetch_vld | input | 1 | CPU fetch in this cycle; the byte enters the queue |
| fetch_addr | input | 16 | CPU fetch address |
| insn_bound | input | 1 | CPU at an instruction boundary |
| q_pop | input | 1 | Queue head byte taken for execution |
| q_flush | input | 1 | Queue flushed (taken branch) |
| bdm_active | input | 1 | CPU already in background mode |
| cpu_wait_stop | input | 1 | CPU in a wait or stop state |
| mem_fail_ws | input | 1 | Debug memory access collided with wait/stop |
| brk_req | output | 1 | Single-cycle background request |
| dbg_clk_sel | output | 1 | Debug clock source select |

## Verification
The assertions assume that the CPU side never pushes into a full queue unless it pops in the same cycle. They also assume that a pop is issued only for a byte that was fetched. The stimulus flushes the queue before each scenario and keeps no more than two unpopped fetches outstanding. Force-mode boundaries are spaced so that two requests never fall in adjacent cycles. The tests leave `bdm_active` low except where they check that a request is suppressed or that the wait/stop status is held.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int DEF_ADDR_W  = 16;
    localparam int DEF_Q_DEPTH = 2;

    // control word bit positions
    localparam int CB_EN   = 0;
    localparam int CB_MODE = 1;
    localparam int CB_CLK  = 2;
    localparam int CB_WS   = 3;
    localparam int CB_WSF  = 4;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CTRL = 2'd1
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic force_sel;
        logic clk_sel;
    } brk_ctl_t;

    typedef struct packed {
        logic ws;
        logic wsf;
    } brk_stat_t;

    typedef struct packed {
        logic vld;
        logic tag;
    } q_ent_t;

    function automatic logic [7:0] pack_ctrl(input brk_ctl_t c, input brk_stat_t s);
        logic [7:0] w;
        w          = '0;
        w[CB_EN]   = c.en;
        w[CB_MODE] = c.force_sel;
        w[CB_CLK]  = c.clk_sel;
        w[CB_WS]   = s.ws;
        w[CB_WSF]  = s.wsf;
        return w;
    endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        dbg_sel,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_wdata,
    output logic [ADDR_W-1:0] dbg_rdata,
    input  logic              cpu_wait_stop,
    input  logic              bdm_active,
    input  logic              mem_fail_ws,
    output logic [ADDR_W-1:0] match_addr,
    output brk_ctl_t          ctl,
    output brk_stat_t         stat
);

    localparam int CW = 8;

    logic wr_addr, wr_ctrl;
    assign wr_addr = dbg_we && (dbg_sel == SEL_ADDR);
    assign wr_ctrl = dbg_we && (dbg_sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_addr <= '0;
            ctl        <= '0;
        end else begin
            if (wr_addr)
                match_addr <= dbg_wdata;
            if (wr_ctrl) begin
                ctl.en        <= dbg_wdata[CB_EN];
                ctl.force_sel <= dbg_wdata[CB_MODE];
                ctl.clk_sel   <= dbg_wdata[CB_CLK];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat.ws <= cpu_wait_stop | (stat.ws & bdm_active);
            if (mem_fail_ws)
                stat.wsf <= 1'b1;
            else if (wr_ctrl && dbg_wdata[CB_WSF])
                stat.wsf <= 1'b0;
        end
    end

    always_comb begin
        dbg_rdata = '0;
        unique case (dbg_sel)
            SEL_ADDR: dbg_rdata = match_addr;
            SEL_CTRL: dbg_rdata[CW-1:0] = pack_ctrl(ctl, stat);
            default:  dbg_rdata = '0;
        endcase
    end

    // R9
    ws_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_wait_stop |=> stat.ws);

    // R10
    wsf_set_chk: assert property (@(posedge clk) disable iff (rst)
        mem_fail_ws |=> stat.wsf);

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic              fetch_vld,
    input  logic              armed,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] match_addr,
    output logic              hit
);

    logic [ADDR_W-1:0] diff;

    assign diff = fetch_addr ^ match_addr;
    assign hit  = fetch_vld && armed && (diff == '0);

endmodule

// File: rtl/bkpt_tagq.sv
module bkpt_tagq
    import bkpt_pkg::*;
#(
    parameter int DEPTH = DEF_Q_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic push_tag,
    input  logic pop,
    input  logic flush,
    output logic tag_fire,
    output logic any_vld
);

    q_ent_t [DEPTH-1:0] cur, base, nxt;
    logic placed;

    always_comb begin
        base = cur;
        if (flush) begin
            base = '0;
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++)
                base[i] = cur[i+1];
            base[DEPTH-1] = '0;
        end
        nxt    = base;
        placed = 1'b0;
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !base[i].vld) begin
                    nxt[i].vld = 1'b1;
                    nxt[i].tag = push_tag;
                    placed     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else
            cur <= nxt;
    end

    assign tag_fire = pop && !flush && cur[0].vld && cur[0].tag;

    always_comb begin
        any_vld = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            any_vld = any_vld | cur[i].vld;
    end

    // R6
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (flush && !push) |=> !any_vld);

endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int Q_DEPTH = DEF_Q_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        dbg_sel,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_wdata,
    output logic [ADDR_W-1:0] dbg_rdata,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              insn_bound,
    input  logic              q_pop,
    input  logic              q_flush,
    input  logic              bdm_active,
    input  logic              cpu_wait_stop,
    input  logic              mem_fail_ws,
    output logic              brk_req,
    output logic              dbg_clk_sel
);

    logic [ADDR_W-1:0] match_addr;
    brk_ctl_t          ctl;
    brk_stat_t         stat;
    logic              hit, armed, force_hit, tag_hit, tag_fire, q_any;
    logic              pend, force_fire, fire;

    bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .dbg_sel       (dbg_sel),
        .dbg_we        (dbg_we),
        .dbg_wdata     (dbg_wdata),
        .dbg_rdata     (dbg_rdata),
        .cpu_wait_stop (cpu_wait_stop),
        .bdm_active    (bdm_active),
        .mem_fail_ws   (mem_fail_ws),
        .match_addr    (match_addr),
        .ctl           (ctl),
        .stat          (stat)
    );

    assign armed = ctl.en && !bdm_active;

    bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .fetch_vld  (fetch_vld),
        .armed      (armed),
        .fetch_addr (fetch_addr),
        .match_addr (match_addr),
        .hit        (hit)
    );

    assign force_hit = hit && ctl.force_sel;
    assign tag_hit   = hit && !ctl.force_sel;

    bkpt_tagq #(.DEPTH(Q_DEPTH)) u_q (
        .clk      (clk),
        .rst      (rst),
        .push     (fetch_vld),
        .push_tag (tag_hit),
        .pop      (q_pop),
        .flush    (q_flush),
        .tag_fire (tag_fire),
        .any_vld  (q_any)
    );

    assign force_fire = insn_bound && ctl.force_sel && (pend || force_hit);
    assign fire       = armed && !brk_req && (force_fire || tag_fire);

    always_ff @(posedge clk) begin
        if (rst || !armed || !ctl.force_sel)
            pend <= 1'b0;
        else if (fire && force_fire)
            pend <= 1'b0;
        else
            pend <= pend || force_hit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            brk_req <= 1'b0;
        else
            brk_req <= fire;
    end

    assign dbg_clk_sel = ctl.clk_sel;

    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |=> !brk_req);

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        brk_req |=> !brk_req);

    // R4
    force_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && insn_bound && ctl.en && ctl.force_sel && !bdm_active && !brk_req) |=> brk_req);

    // R7
    bdm_block_chk: assert property (@(posedge clk) disable iff (rst)
        (bdm_active && !brk_req) |=> !brk_req);

endmodule

// File: tb/sim_dbg_brk_unit.sv
module sim_dbg_brk_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  dbg_sel;
    logic        dbg_we;
    logic [15:0] dbg_wdata, dbg_rdata;
    logic        fetch_vld;
    logic [15:0] fetch_addr;
    logic        insn_bound, q_pop, q_flush, bdm_active, cpu_wait_stop, mem_fail_ws;
    logic        brk_req, dbg_clk_sel;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int exp_q[$];
    string phase = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dbg_brk_unit u0 (
        .clk(clk), .rst(rst), .dbg_sel(dbg_sel), .dbg_we(dbg_we),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .fetch_vld(fetch_vld),
        .fetch_addr(fetch_addr), .insn_bound(insn_bound), .q_pop(q_pop),
        .q_flush(q_flush), .bdm_active(bdm_active), .cpu_wait_stop(cpu_wait_stop),
        .mem_fail_ws(mem_fail_ws), .brk_req(brk_req), .dbg_clk_sel(dbg_clk_sel)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare brk_req with the scoreboard every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp;
            exp = 1'b0;
            while (exp_q.size() > 0 && exp_q[0] < cyc) void'(exp_q.pop_front());
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                exp = 1'b1;
                void'(exp_q.pop_front());
            end
            total++;
            if (brk_req !== exp) begin
                bad++;
                $display("FAIL %s brk_req cyc=%0d actual=%0b expected=%0b", phase, cyc, brk_req, exp);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        dbg_we = 0; fetch_vld = 0; insn_bound = 0; q_pop = 0; q_flush = 0;
        mem_fail_ws = 0;
    endtask

    // one CPU-side cycle; exp_brk pushes the expected pulse
    task automatic drive(input logic fv, input logic [15:0] fa, input logic bnd,
                         input logic pop, input logic fl, input bit exp_brk);
        @(negedge clk); #1;
        idle_inputs();
        fetch_vld = fv; fetch_addr = fa; insn_bound = bnd; q_pop = pop; q_flush = fl;
        if (exp_brk) exp_q.push_back(cyc + 1);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk); #1;
        idle_inputs();
        dbg_sel = sel; dbg_we = 1; dbg_wdata = d;
    endtask

    task automatic rd(input string req, input logic [1:0] sel, input logic [15:0] exp);
        @(negedge clk); #1;
        idle_inputs();
        dbg_sel = sel;
        #1;
        chk(req, dbg_rdata, exp);
    endtask

    task automatic clean();
        drive(0, 16'h0, 0, 0, 1, 0);
        drive(0, 16'h0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; idle_inputs(); dbg_sel = 0; dbg_wdata = 0; fetch_addr = 0;
        bdm_active = 0; cpu_wait_stop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        rd("R1", 2'd0, 16'h0000);
        rd("R1", 2'd1, 16'h0000);
        chk("R1", {15'h0, dbg_clk_sel}, 16'h0);

        // R2 register access
        phase = "R2";
        wr(2'd0, 16'hA5C3);
        rd("R2", 2'd0, 16'hA5C3);
        wr(2'd1, 16'hFFE7);
        rd("R2", 2'd1, 16'h0007);
        rd("R2", 2'd2, 16'h0000);
        // R11 clock select
        chk("R11", {15'h0, dbg_clk_sel}, 16'h1);
        wr(2'd1, 16'h0003);
        rd("R11", 2'd1, 16'h0003);
        chk("R11", {15'h0, dbg_clk_sel}, 16'h0);

        // R4 force mode
        phase = "R4";
        wr(2'd0, 16'h1234);
        clean();
        drive(1, 16'h1234, 0, 0, 0, 0);
        drive(1, 16'h1235, 1, 0, 0, 1);
        drive(0, 16'h0, 0, 0, 0, 0);
        drive(0, 16'h0, 1, 0, 0, 0);
        clean();
        drive(1, 16'h1234, 1, 0, 0, 1);
        drive(0, 16'h0, 0, 0, 0, 0);
        drive(0, 16'h0, 1, 0, 0, 0);

        // R8 full-width compare
        phase = "R8";
        clean();
        drive(1, 16'h9234, 0, 0, 0, 0);
        drive(0, 16'h0, 1, 0, 0, 0);
        drive(1, 16'h1235, 1, 0, 0, 0);
        drive(0, 16'h0, 1, 0, 0, 0);

        // R7 blocked while in background
        phase = "R7";
        clean();
        bdm_active = 1;
        drive(1, 16'h1234, 1, 0, 0, 0);
        drive(0, 16'h0, 1, 0, 0, 0);
        bdm_active = 0;
        drive(0, 16'h0, 1, 0, 0, 0);

        // R5 tag mode
        phase = "R5";
        wr(2'd1, 16'h0001);
        clean();
        drive(1, 16'h1234, 0, 0, 0, 0);
        drive(1, 16'h1236, 1, 0, 0, 0);
        drive(0, 16'h0, 0, 1, 0, 1);
        drive(0, 16'h0, 0, 1, 0, 0);
        drive(0, 16'h0, 0, 0, 0, 0);
        clean();
        drive(1, 16'h1000, 0, 0, 0, 0);
        drive(1, 16'h1234, 0, 0, 0, 0);
        drive(0, 16'h0, 0, 1, 0, 0);
        drive(0, 16'h0, 0, 1, 0, 1);
        drive(0, 16'h0, 0, 0, 0, 0);

        // R6 flush discards tags
        phase = "R6";
        clean();
        drive(1, 16'h1234, 0, 0, 0, 0);
        drive(1, 16'h2000, 0, 0, 1, 0);
        drive(0, 16'h0, 0, 1, 0, 0);
        drive(0, 16'h0, 0, 1, 0, 0);
        drive(0, 16'h0, 0, 0, 0, 0);

        // R7 tag pop while in background
        phase = "R7";
        clean();
        drive(1, 16'h1234, 0, 0, 0, 0);
        bdm_active = 1;
        drive(0, 16'h0, 0, 1, 0, 0);
        drive(0, 16'h0, 0, 0, 0, 0);
        bdm_active = 0;

        // R3 disabled
        phase = "R3";
        wr(2'd1, 16'h0002);
        clean();
        drive(1, 16'h1234, 1, 0, 0, 0);
        drive(0, 16'h0, 1, 0, 0, 0);
        wr(2'd1, 16'h0000);
        clean();
        drive(1, 16'h1234, 0, 0, 0, 0);
        drive(0, 16'h0, 0, 1, 0, 0);
        drive(0, 16'h0, 0, 0, 0, 0);

        // R9 wait/stop status
        phase = "R9";
        cpu_wait_stop = 1;
        drive(0, 16'h0, 0, 0, 0, 0);
        rd("R9", 2'd1, 16'h0008);
        cpu_wait_stop = 0; bdm_active = 1;
        drive(0, 16'h0, 0, 0, 0, 0);
        rd("R9", 2'd1, 16'h0008);
        bdm_active = 0;
        drive(0, 16'h0, 0, 0, 0, 0);
        rd("R9", 2'd1, 16'h0000);

        // R10 collision flag
        phase = "R10";
        @(negedge clk); #1; idle_inputs(); mem_fail_ws = 1;
        rd("R10", 2'd1, 16'h0010);
        wr(2'd1, 16'h0010);
        rd("R10", 2'd1, 16'h0000);
        @(negedge clk); #1; idle_inputs();
        mem_fail_ws = 1; dbg_sel = 2'd1; dbg_we = 1; dbg_wdata = 16'h0010;
        rd("R10", 2'd1, 16'h0010);

        drive(0, 16'h0, 0, 0, 0, 0);
        drive(0, 16'h0, 0, 0, 0, 0);
        done = 1'b1;
        chk("R7", {15'h0, brk_req}, 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule